// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor for a compact load/store instruction subset: register-register ALU operations, immediate ALU operations, word load and store, equal/not-equal branches, absolute jumps, register jumps, and their linking forms. Each instruction retires on a single rising clock edge. On that edge the core writes its register file or data memory, moves the program counter, and captures the next instruction word into an explicit instruction register.

The core talks to memory through a word-addressed interface with two channels. The fetch channel presents a word index and takes back the instruction word in the same cycle. The data channel presents a word index, write data and a write strobe, and takes back read data in the same cycle. A bench or system can back both channels with one array. In that case a store can rewrite code.

The program counter always holds the byte address just past the instruction in the instruction register, which is the value a link writes. A sequential instruction fetches at that held address. A taken branch or a jump fetches at its target. No instruction after a redirect is ever executed.

Top module: `onecycle_cpu`

## Requirements
- R1: While reset is asserted, the fetch index is 0 and the data write strobe is low. An assertion of rst_n takes effect asynchronously, even in the middle of a run.
- R2: For opcode 0x00, the func field selects the operation and the result is written to register rd. The operations are add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, nor 0x27 and slt 0x2A, each taking operand rs and operand rt. slt is a signed compare giving 1 or 0. Shift left logical 0x00 and shift right logical 0x02 shift rt by the shamt field, bits 10..6.
- R3: The immediate opcodes write register rt: addi 0x08, slti 0x0A, andi 0x0C, ori 0x0D, xori 0x0E and lui 0x0F. addi, slti and xori sign-extend the 16-bit immediate. andi and ori zero-extend it. lui places it in the upper half with zeros below. slti compares signed.
- R4: lw (0x23) loads rt from the word at rs plus the sign-extended immediate. sw (0x2B) stores rt to that address. The data write strobe is high only while a sw is being executed.
- R5: beq (0x04) and bne (0x05) compare rs with rt. When taken, the next instruction comes from the branch address + 4 + 4 × the sign-extended immediate. When not taken, execution falls through. Instructions skipped by a taken branch never execute.
- R6: j (0x02) and jal (0x03) continue at the address whose bits 31..28 come from the branch address + 4, bits 27..2 from the 26-bit index field, and bits 1..0 are zero.
- R7: jr (func 0x08) and jalr (func 0x09) continue at the address held in rs. jal and jalr write the address of the jump + 4 into register 31.
- R8: Register 0 reads as zero, and a write to it has no effect.
- R9: An unknown opcode, or an unknown func under opcode 0x00, writes no register and no memory, and execution falls through.
- R10: The PC and the instruction register update on the same edge. The first instruction word is fetched from index 0. After rst_n is released, the instruction register is loaded with that word on the third rising edge. The fetch index then steps by one per cycle through straight-line code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released through a two-flop synchronizer |
| imem_addr | output | MEM_AW | Word index of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | MEM_AW | Word index of the load or store |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, valid in the same cycle |

## Verification
The bench targets a negative immediate used as a load/store offset and as a backward branch offset. If the sign extension were wrong, the core would write a word far from the expected slot, or it would leave the loop at once with the wrong count. It tests xori against slti and andi/ori using operands whose upper halves differ, so choosing the wrong extension changes the stored result. It also checks that a taken branch, a jump and a register jump skip the words that follow them, and that a link holds the jump address plus four. A core that fetched the sequential word after a redirect would overwrite the stored marker, and an off-by-one in the link value would return a different number. Further checks cover writes to register 0, unknown opcodes and func codes, and exact fetch timing after reset. These show whether the core lets state leak through a no-op or whether the reset release is misaligned by a cycle.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;

  localparam int unsigned XLEN  = 32;
  localparam int unsigned NREGS = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] OPC_JAL   = 6'h03;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_BNE   = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_UPPER
  } alu_op_e;

  typedef enum logic [2:0] {
    NXT_SEQ, NXT_BEQ, NXT_BNE, NXT_JUMP, NXT_REG
  } next_sel_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_LINK
  } wb_sel_e;

  typedef enum logic [1:0] {
    DST_RD, DST_RT, DST_LINK
  } dst_sel_e;

  typedef struct packed {
    alu_op_e   alu_op;
    logic      b_is_imm;
    logic      imm_sext;
    logic      reg_we;
    dst_sel_e  dst;
    wb_sel_e   wb;
    logic      mem_we;
    next_sel_e nxt;
  } ctrl_t;

endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/oc_decode.sv
module oc_decode
  import onecycle_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.alu_op   = ALU_ADD;
    ctrl.b_is_imm = 1'b0;
    ctrl.imm_sext = 1'b0;
    ctrl.reg_we   = 1'b0;
    ctrl.dst      = DST_RT;
    ctrl.wb       = WB_ALU;
    ctrl.mem_we   = 1'b0;
    ctrl.nxt      = NXT_SEQ;

    case (opc)
      OPC_RTYPE: begin
        ctrl.dst = DST_RD;
        case (fn)
          FN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_we = 1'b1; end
          FN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_we = 1'b1; end
          FN_AND: begin ctrl.alu_op = ALU_AND; ctrl.reg_we = 1'b1; end
          FN_OR:  begin ctrl.alu_op = ALU_OR;  ctrl.reg_we = 1'b1; end
          FN_XOR: begin ctrl.alu_op = ALU_XOR; ctrl.reg_we = 1'b1; end
          FN_NOR: begin ctrl.alu_op = ALU_NOR; ctrl.reg_we = 1'b1; end
          FN_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_we = 1'b1; end
          FN_SLL: begin ctrl.alu_op = ALU_SLL; ctrl.reg_we = 1'b1; end
          FN_SRL: begin ctrl.alu_op = ALU_SRL; ctrl.reg_we = 1'b1; end
          FN_JR: begin
            ctrl.nxt = NXT_REG;
          end
          FN_JALR: begin
            ctrl.nxt    = NXT_REG;
            ctrl.reg_we = 1'b1;
            ctrl.dst    = DST_LINK;
            ctrl.wb     = WB_LINK;
          end
          default: begin
            ctrl.reg_we = 1'b0;
          end
        endcase
      end
      OPC_ADDI: begin
        ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.alu_op = ALU_SLT; ctrl.b_is_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_ANDI: begin
        ctrl.alu_op = ALU_AND; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_ORI: begin
        ctrl.alu_op = ALU_OR; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_XORI: begin
        ctrl.alu_op = ALU_XOR; ctrl.b_is_imm = 1'b1; ctrl.imm_sext = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_LUI: begin
        ctrl.alu_op = ALU_UPPER; ctrl.b_is_imm = 1'b1; ctrl.reg_we = 1'b1;
      end
      OPC_LW: begin
        ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.imm_sext = 1'b1;
        ctrl.reg_we = 1'b1; ctrl.wb = WB_MEM;
      end
      OPC_SW: begin
        ctrl.alu_op = ALU_ADD; ctrl.b_is_imm = 1'b1; ctrl.imm_sext = 1'b1;
        ctrl.mem_we = 1'b1;
      end
      OPC_BEQ: ctrl.nxt = NXT_BEQ;
      OPC_BNE: ctrl.nxt = NXT_BNE;
      OPC_J:   ctrl.nxt = NXT_JUMP;
      OPC_JAL: begin
        ctrl.nxt    = NXT_JUMP;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_LINK;
      end
      default: begin
        ctrl.nxt = NXT_SEQ;
      end
    endcase
  end

endmodule

// File: rtl/oc_alu.sv
module oc_alu
  import onecycle_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] y
);

  localparam int unsigned HALF = WIDTH / 2;

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_NOR:   y = ~(a | b);
      ALU_SLT:   y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL:   y = b << shamt;
      ALU_SRL:   y = b >> shamt;
      ALU_UPPER: y = b << HALF;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned NREGS  = 32,
  parameter int unsigned NREAD  = 2,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx  [NREAD],
  output logic [WIDTH-1:0] rd_data [NREAD],
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data
);

  logic [WIDTH-1:0] regs_q [NREGS];
  logic             wr_fire;

  assign wr_fire = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      regs_q[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_read
    assign rd_data[p] = (rd_idx[p] == '0) ? '0 : regs_q[rd_idx[p]];
  end

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
  import onecycle_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [MEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic [MEM_AW-1:0] dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  input  logic [XLEN-1:0]   dmem_rdata
);

  localparam int unsigned IDX_W = $clog2(NREGS);
  localparam int unsigned SHW   = $clog2(XLEN);
  localparam int unsigned IMM_W = 16;

  logic            core_rst_n;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ir_q, ir_d;

  logic [5:0]       f_opc, f_fn;
  logic [IDX_W-1:0] f_rs, f_rt, f_rd;
  logic [SHW-1:0]   f_shamt;
  logic [IMM_W-1:0] f_imm;
  logic [25:0]      f_jidx;

  ctrl_t            ctrl;
  logic [IDX_W-1:0] rf_ridx [2];
  logic [XLEN-1:0]  rf_rdata [2];
  logic [XLEN-1:0]  rs_val, rt_val;
  logic [XLEN-1:0]  imm_sx, imm_ext, alu_b, alu_y;
  logic             rf_we;
  logic [IDX_W-1:0] rf_waddr;
  logic [XLEN-1:0]  rf_wdata;

  logic [XLEN-1:0]  br_tgt, jmp_tgt, redir_tgt, fetch_pc;
  logic             redirect;

  oc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  assign f_opc   = ir_q[31:26];
  assign f_rs    = ir_q[25:21];
  assign f_rt    = ir_q[20:16];
  assign f_rd    = ir_q[15:11];
  assign f_shamt = ir_q[10:6];
  assign f_fn    = ir_q[5:0];
  assign f_imm   = ir_q[15:0];
  assign f_jidx  = ir_q[25:0];

  oc_decode u_decode (
    .opc  (f_opc),
    .fn   (f_fn),
    .ctrl (ctrl)
  );

  assign rf_ridx[0] = f_rs;
  assign rf_ridx[1] = f_rt;

  oc_regfile #(.WIDTH(XLEN), .NREGS(NREGS), .NREAD(2)) u_regfile (
    .clk     (clk),
    .rd_idx  (rf_ridx),
    .rd_data (rf_rdata),
    .wr_en   (rf_we),
    .wr_idx  (rf_waddr),
    .wr_data (rf_wdata)
  );

  assign rs_val = rf_rdata[0];
  assign rt_val = rf_rdata[1];

  assign imm_sx  = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign imm_ext = ctrl.imm_sext ? imm_sx : {{(XLEN-IMM_W){1'b0}}, f_imm};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

  oc_alu #(.WIDTH(XLEN)) u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (f_shamt),
    .y     (alu_y)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RD:   rf_waddr = f_rd;
      DST_LINK: rf_waddr = LINK_REG;
      default:  rf_waddr = f_rt;
    endcase
  end

  always_comb begin
    case (ctrl.wb)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_q;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we = ctrl.reg_we & core_rst_n;

  assign dmem_addr  = alu_y[MEM_AW+1:2];
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & core_rst_n;

  assign br_tgt  = pc_q + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], f_jidx, 2'b00};

  always_comb begin
    redirect  = 1'b0;
    redir_tgt = pc_q;
    case (ctrl.nxt)
      NXT_BEQ: begin
        redirect  = (rs_val == rt_val);
        redir_tgt = br_tgt;
      end
      NXT_BNE: begin
        redirect  = (rs_val != rt_val);
        redir_tgt = br_tgt;
      end
      NXT_JUMP: begin
        redirect  = 1'b1;
        redir_tgt = jmp_tgt;
      end
      NXT_REG: begin
        redirect  = 1'b1;
        redir_tgt = rs_val;
      end
      default: begin
        redirect  = 1'b0;
      end
    endcase
  end

  assign fetch_pc  = redirect ? redir_tgt : pc_q;
  assign imem_addr = fetch_pc[MEM_AW+1:2];
  assign pc_d      = fetch_pc + XLEN'(4);
  assign ir_d      = imem_rdata;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      pc_q <= pc_d;
      ir_q <= ir_d;
    end
  end

endmodule

// File: rtl/onecycle_cpu_chk.sv
module onecycle_cpu_chk
  import onecycle_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic [XLEN-1:0]   pc_q,
  input logic [XLEN-1:0]   ir_q,
  input logic [XLEN-1:0]   rs_val,
  input logic [MEM_AW-1:0] imem_addr,
  input logic              dmem_we
);

  logic [5:0]      c_opc, c_fn;
  logic            c_flow, c_jump;
  logic [XLEN-1:0] seq_exp, jmp_exp;

  assign c_opc   = ir_q[31:26];
  assign c_fn    = ir_q[5:0];
  assign c_jump  = (c_opc == OPC_J) || (c_opc == OPC_JAL);
  assign c_flow  = c_jump || (c_opc == OPC_BEQ) || (c_opc == OPC_BNE) ||
                   ((c_opc == OPC_RTYPE) && ((c_fn == FN_JR) || (c_fn == FN_JALR)));
  assign seq_exp = pc_q + 32'd4;
  assign jmp_exp = {pc_q[31:28], ir_q[25:0], 2'b00} + 32'd4;

  always @(posedge clk) begin
    if (!core_rst_n) begin
      p_reset_idle_r1: assert (imem_addr == '0 && !dmem_we)
        else $error("reset: fetch index or store strobe not idle");
    end
  end

  p_seq_step_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !c_flow |=> pc_q == $past(seq_exp));

  p_jump_target_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    c_jump |=> pc_q == $past(jmp_exp));

  p_store_only_sw_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    dmem_we |-> c_opc == OPC_SW);

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (ir_q[25:21] == 5'd0) |-> rs_val == '0);

endmodule

bind onecycle_cpu onecycle_cpu_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .rs_val     (rs_val),
  .imem_addr  (imem_addr),
  .dmem_we    (dmem_we)
);

// File: tb/tb_onecycle_cpu.sv
module tb_onecycle_cpu;

  localparam int MEM_AW = 10;
  localparam int MWORDS = 1 << MEM_AW;
  localparam int SLOT   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [MEM_AW-1:0] imem_addr, dmem_addr;
  logic [31:0]       imem_rdata, dmem_wdata, dmem_rdata;
  logic              dmem_we;
  logic [31:0]       mem [MWORDS];

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  onecycle_cpu #(.MEM_AW(MEM_AW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = mem[imem_addr];
  assign dmem_rdata = mem[dmem_addr];

  always @(posedge clk) begin
    if (dmem_we) mem[dmem_addr] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input int op, input int idx);
    return {6'(op), 26'(idx)};
  endfunction

  // r1 = 0xFFFF_FFF3, r2 = 0x0000_0007, r3 preset to 0x55; result in r3
  localparam int NV = 19;
  localparam logic [31:0] V_INS [NV] = '{
    enc_r(1, 2, 3, 0, 'h20), enc_r(1, 2, 3, 0, 'h22), enc_r(1, 2, 3, 0, 'h24),
    enc_r(1, 2, 3, 0, 'h25), enc_r(1, 2, 3, 0, 'h26), enc_r(1, 2, 3, 0, 'h27),
    enc_r(1, 2, 3, 0, 'h2A), enc_r(2, 1, 3, 0, 'h2A), enc_r(0, 2, 3, 4, 'h00),
    enc_r(0, 1, 3, 4, 'h02),
    enc_i('h08, 1, 3, -3), enc_i('h0C, 1, 3, 'hF0F0), enc_i('h0D, 2, 3, 'h8000),
    enc_i('h0E, 2, 3, 'hFFFF), enc_i('h0A, 1, 3, -12), enc_i('h0A, 2, 3, -1),
    enc_i('h0F, 0, 3, 'h1234),
    enc_i('h3F, 1, 3, 5), enc_r(1, 2, 3, 0, 'h3F)
  };
  localparam logic [31:0] V_EXP [NV] = '{
    32'hFFFF_FFFA, 32'hFFFF_FFEC, 32'h0000_0003, 32'hFFFF_FFF7, 32'hFFFF_FFF4,
    32'h0000_0008, 32'h0000_0001, 32'h0000_0000, 32'h0000_0070, 32'h0FFF_FFFF,
    32'hFFFF_FFF0, 32'h0000_F0F0, 32'h0000_8007, 32'hFFFF_FFF8, 32'h0000_0001,
    32'h0000_0000, 32'h1234_0000,
    32'h0000_0055, 32'h0000_0055
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < MWORDS; i++) mem[i] = 32'h0;
  endtask

  task automatic release_run(input int ncyc);
    repeat (2) @(negedge clk);
    chk("R1 fetch index in reset", 32'(imem_addr), 32'h0);
    chk("R1 store strobe in reset", 32'(dmem_we), 32'h0);
    rst_n = 1'b1;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic load_template(input logic [31:0] op_word);
    mem[0] = enc_i('h0F, 0, 1, 'hFFFF);
    mem[1] = enc_i('h0D, 1, 1, 'hFFF3);
    mem[2] = enc_i('h0F, 0, 2, 0);
    mem[3] = enc_i('h0D, 2, 2, 7);
    mem[4] = enc_i('h08, 0, 3, 'h55);
    mem[5] = op_word;
    mem[6] = enc_i('h2B, 0, 3, 'h100);
    mem[7] = enc_j('h02, 7);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog (R1-related run hang): actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    // table walk: R2, R3, R9
    for (int v = 0; v < NV; v++) begin
      hold_reset();
      load_template(V_INS[v]);
      release_run(20);
      chk((v < 10) ? "R2 register ALU op" : (v < 17) ? "R3 immediate op" : "R9 unknown is no-op",
          mem[SLOT], V_EXP[v]);
    end

    // R10: fetch timing after release
    hold_reset();
    load_template(V_INS[0]);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 index after edge 1", 32'(imem_addr), 32'd0);
    @(negedge clk);
    chk("R10 index after edge 2", 32'(imem_addr), 32'd0);
    @(negedge clk);
    chk("R10 index after edge 3", 32'(imem_addr), 32'd1);
    @(negedge clk);
    chk("R10 index after edge 4", 32'(imem_addr), 32'd2);

    // R5 beq taken skips two words
    hold_reset();
    mem[0] = enc_i('h08, 0, 1, 1);
    mem[1] = enc_i('h04, 0, 0, 2);
    mem[2] = enc_i('h08, 0, 1, 2);
    mem[3] = enc_i('h08, 0, 1, 3);
    mem[4] = enc_i('h2B, 0, 1, 'h100);
    mem[5] = enc_j('h02, 5);
    release_run(16);
    chk("R5 beq taken", mem[SLOT], 32'd1);

    // R5 bne taken
    hold_reset();
    mem[0] = enc_i('h08, 0, 1, 7);
    mem[1] = enc_i('h05, 1, 0, 1);
    mem[2] = enc_i('h08, 0, 1, 9);
    mem[3] = enc_i('h2B, 0, 1, 'h100);
    mem[4] = enc_j('h02, 4);
    release_run(16);
    chk("R5 bne taken", mem[SLOT], 32'd7);

    // R5 bne not taken
    mem[1] = enc_i('h05, 0, 0, 1);
    mem[SLOT] = 32'h0;
    rst_n = 1'b0;
    release_run(16);
    chk("R5 bne not taken", mem[SLOT], 32'd9);

    // R5 backward branch loop counts to 3
    hold_reset();
    mem[0] = enc_i('h08, 0, 4, 3);
    mem[1] = enc_i('h08, 0, 1, 0);
    mem[2] = enc_i('h08, 1, 1, 1);
    mem[3] = enc_i('h05, 1, 4, -2);
    mem[4] = enc_i('h2B, 0, 1, 'h100);
    mem[5] = enc_j('h02, 5);
    release_run(24);
    chk("R5 backward bne loop", mem[SLOT], 32'd3);

    // R6 j forward
    hold_reset();
    mem[0] = enc_i('h08, 0, 1, 4);
    mem[1] = enc_j('h02, 3);
    mem[2] = enc_i('h08, 0, 1, 6);
    mem[3] = enc_i('h2B, 0, 1, 'h100);
    mem[4] = enc_j('h02, 4);
    release_run(16);
    chk("R6 j skips word", mem[SLOT], 32'd4);

    // R6/R7 jal link
    hold_reset();
    mem[0] = enc_j('h03, 3);
    mem[1] = enc_i('h08, 0, 31, 'h77);
    mem[2] = enc_i('h08, 0, 31, 'h77);
    mem[3] = enc_i('h2B, 0, 31, 'h100);
    mem[4] = enc_j('h02, 4);
    release_run(16);
    chk("R7 jal link value", mem[SLOT], 32'd4);

    // R7 jalr
    hold_reset();
    mem[0] = enc_i('h08, 0, 5, 16);
    mem[1] = enc_r(5, 0, 0, 0, 'h09);
    mem[2] = enc_i('h08, 0, 31, 'h77);
    mem[3] = enc_i('h08, 0, 31, 'h77);
    mem[4] = enc_i('h2B, 0, 31, 'h100);
    mem[5] = enc_j('h02, 5);
    release_run(16);
    chk("R7 jalr link value", mem[SLOT], 32'd8);

    // R7 jr
    hold_reset();
    mem[0] = enc_i('h08, 0, 6, 5);
    mem[1] = enc_i('h08, 0, 5, 16);
    mem[2] = enc_r(5, 0, 0, 0, 'h08);
    mem[3] = enc_i('h08, 0, 6, 9);
    mem[4] = enc_i('h2B, 0, 6, 'h100);
    mem[5] = enc_j('h02, 5);
    release_run(16);
    chk("R7 jr target", mem[SLOT], 32'd5);

    // R4 store/load with negative offset
    hold_reset();
    mem[0] = enc_i('h08, 0, 4, 'h110);
    mem[1] = enc_i('h08, 0, 1, 'h1AB);
    mem[2] = enc_i('h2B, 4, 1, -8);
    mem[3] = enc_i('h23, 4, 3, -8);
    mem[4] = enc_i('h2B, 0, 3, 'h100);
    mem[5] = enc_j('h02, 5);
    release_run(16);
    chk("R4 sw to base-8", mem[66], 32'h1AB);
    chk("R4 lw back", mem[SLOT], 32'h1AB);
    chk("R4 neighbour untouched", mem[67], 32'h0);

    // R8 register 0
    hold_reset();
    mem[0] = enc_i('h08, 0, 0, 'h33);
    mem[1] = enc_i('h2B, 0, 0, 'h100);
    mem[2] = enc_j('h02, 2);
    mem[SLOT] = 32'hFFFF;
    release_run(12);
    chk("R8 r0 stays zero", mem[SLOT], 32'h0);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    chk("R1 running index before reset", 32'(imem_addr), 32'd2);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset fetch index", 32'(imem_addr), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule